// File: doc/BRIEF.md
# Two-Wire Bus Slave Front End

This block is the bus-facing half of a small two-wire serial slave. It oversamples the clock and data lines with the system clock and cleans them up. From them it finds the start and stop conditions and shifts bytes in, most significant bit first. It acknowledges by enabling a pull-down on the data line. Every byte after the address byte goes to a command layer as a valid/ready stream, along with strobes that mark where a transaction begins and ends.

The first byte of each transaction has no read/write bit. It is a fixed 4-bit device type, `0101`, followed by four address bits, and those four bits must equal the strap pins, so sixteen devices can share one bus. While the nonvolatile store is busy, the address byte goes unacknowledged, so the host can poll until it completes.

Read data moves in the other direction. During the acknowledge slot of a received byte, the command layer may offer a byte, which is then shifted out on the following eight clocks. The command layer can instead request a stepping phase. In that phase, every clock-high pulse is reported together with the data line level, until the transaction ends.

Top module: `tws_slave_frontend`

Back-pressure rules:
- Received bytes cannot be stalled, because the bus has no clock stretching. `rx_valid_o` rises when the eighth bit is sampled. It falls either when `rx_ready_i` is seen or at the falling clock edge that ends that bit, whichever comes first.
- A byte that has not been taken by that edge is dropped. It is not acknowledged, and the rest of the transaction is ignored.
- `tx_ready_o` is offered only during the acknowledge slot of a non-address byte. A byte accepted there is sent next.

## Requirements
- R1: After reset, the data pull-down is released, and `rx_valid_o`, `tx_ready_o`, `step_o` and both frame strobes are low.
- R2: When a START is followed by the byte `{0101, strap_addr_i}`, the block pulls SDA low for the whole ninth clock and pulses `frame_start_o` once as the pull-down begins.
- R3: If the upper nibble of the first byte is not 0101, or the lower nibble does not equal `strap_addr_i`, the block gives no acknowledge, delivers no byte and stays silent until the next START.
- R4: If `nv_busy_i` is high at the acknowledge decision of a matching address byte, no acknowledge is given and no frame starts.
- R5: Each byte after the address is presented on `rx_data_o` (first bit on the wire becomes bit 7) with `rx_valid_o`. While valid is held without ready, the data is stable, and an accepted byte is acknowledged.
- R6: A byte not accepted by the falling SCL edge that ends its eighth bit is not acknowledged. That byte and all later bytes of the transaction are discarded.
- R7: A byte accepted through `tx_valid_i`/`tx_ready_o` in the acknowledge slot of a non-address byte is sent on the next eight clocks, bit 7 first. Each bit changes only after an SCL falling edge. Exactly one byte is accepted per slot.
- R8: If `step_mode_i` is high when the acknowledge slot of a non-address byte ends, then each later SCL rising edge gives a one-cycle `step_o` pulse. `step_up_o` equals the SDA level (1 = up, 0 = down).
- R9: A STOP, or a START in any state, returns the block to waiting for an address with SDA released. `frame_end_o` pulses if an address had been acknowledged since the previous condition.
- R10: The block only ever enables a pull-down on SDA. It releases SDA in the master's acknowledge slot after a read byte and at every time other than its own acknowledge slots and zero bits it sends.
- R11: An SCL pulse lasting fewer than `FILT_LEN` system clocks is ignored by the bit shifter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_drive_low_o | output | 1 | Enables the open-drain pull-down on SDA |
| strap_addr_i | input | 4 | Strap pins giving the lower nibble of the address |
| nv_busy_i | input | 1 | Nonvolatile store busy; address bytes are not acknowledged |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte available |
| rx_ready_i | input | 1 | Command layer takes the received byte |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | Byte to send is offered |
| tx_ready_o | output | 1 | Block can take a byte to send |
| step_mode_i | input | 1 | Enter the stepping phase after the current acknowledge |
| step_o | output | 1 | One-cycle pulse per SCL rising edge in the stepping phase |
| step_up_o | output | 1 | Direction of the last step (SDA level) |
| frame_start_o | output | 1 | Pulse when an address is acknowledged |
| frame_end_o | output | 1 | Pulse when an engaged transaction ends |

## Verification
Each bus pin passes through two synchronizer flops and a filter that needs `FILT_LEN` (2) agreeing samples. After that, the engine adds one register. So the acknowledge pull-down, `rx_valid_o`, a sent bit and `step_o` all appear about five system clocks after the SCL pin edge that causes them. The bench keeps SCL low and high for ten clocks each. It reads SDA five clocks into the high phase, which is well after any response is due and before the next edge. Stream handshakes and strobes are counted at the falling system clock edge, and those counts are compared only after the bus sequence that produces them has finished.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] DEV_TYPE = 4'b0101;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_STEP,
    ST_IGNORE
  } tws_state_e;

  typedef struct packed {
    logic rise;
    logic fall;
    logic start;
    logic stop;
    logic sda;
  } bus_evt_t;
endpackage

// File: rtl/tws_pin_filter.sv
module tws_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   level_q;

  // synchronizer chain, idle-high after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end

  // level changes only after FILT_LEN agreeing samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b1;
      cnt_q   <= '0;
    end else if (sync_q[SYNC_STAGES-1] != level_q) begin
      if (cnt_q == CW'(FILT_LEN - 1)) begin
        level_q <= sync_q[SYNC_STAGES-1];
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign level_o = level_q;
endmodule

// File: rtl/tws_cond_detect.sv
module tws_cond_detect
  import tws_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_f,
  input  logic     sda_f,
  output bus_evt_t evt_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  always_comb begin
    evt_o.rise  = scl_f & ~scl_q;
    evt_o.fall  = ~scl_f & scl_q;
    evt_o.start = scl_f & scl_q & sda_q & ~sda_f;
    evt_o.stop  = scl_f & scl_q & ~sda_q & sda_f;
    evt_o.sda   = sda_f;
  end
endmodule

// File: rtl/tws_byte_engine.sv
module tws_byte_engine
  import tws_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  bus_evt_t          evt_i,
  input  logic [3:0]        strap_i,
  input  logic              nv_busy_i,
  input  logic              step_mode_i,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              step_o,
  output logic              step_up_o,
  output logic              frame_start_o,
  output logic              frame_end_o,
  output logic              sda_low_o
);
  localparam int BCW = $clog2(BYTE_W);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(BYTE_W - 1);

  tws_state_e        state_q;
  logic [BCW-1:0]    bitcnt_q;
  logic [BYTE_W-1:0] shreg_q, txsh_q, rx_data_q;
  logic is_addr_q, byte_full_q, rx_valid_q, rx_taken_q, tx_loaded_q;
  logic drive_low_q, engaged_q, step_q, step_up_q, fstart_q, fend_q;

  logic addr_hit, ack_ok, rx_hs, tx_hs, tx_go;
  logic [BYTE_W-1:0] tx_next;

  assign addr_hit   = (shreg_q == {DEV_TYPE, strap_i});
  assign rx_hs      = rx_valid_q & rx_ready_i;
  assign tx_ready_o = (state_q == ST_RX_ACK) & ~is_addr_q & ~tx_loaded_q;
  assign tx_hs      = tx_ready_o & tx_valid_i;
  assign tx_go      = tx_loaded_q | tx_hs;
  assign tx_next    = tx_loaded_q ? txsh_q : tx_data_i;
  assign ack_ok     = is_addr_q ? (addr_hit & ~nv_busy_i) : (rx_taken_q | rx_hs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      bitcnt_q    <= '0;
      shreg_q     <= '0;
      txsh_q      <= '0;
      rx_data_q   <= '0;
      is_addr_q   <= 1'b0;
      byte_full_q <= 1'b0;
      rx_valid_q  <= 1'b0;
      rx_taken_q  <= 1'b0;
      tx_loaded_q <= 1'b0;
      drive_low_q <= 1'b0;
      engaged_q   <= 1'b0;
      step_q      <= 1'b0;
      step_up_q   <= 1'b0;
      fstart_q    <= 1'b0;
      fend_q      <= 1'b0;
    end else begin
      step_q   <= 1'b0;
      fstart_q <= 1'b0;
      fend_q   <= 1'b0;
      if (rx_hs) begin
        rx_valid_q <= 1'b0;
        rx_taken_q <= 1'b1;
      end
      if (tx_hs) begin
        txsh_q      <= tx_data_i;
        tx_loaded_q <= 1'b1;
      end
      if (evt_i.start || evt_i.stop) begin
        fend_q      <= engaged_q;
        engaged_q   <= 1'b0;
        drive_low_q <= 1'b0;
        rx_valid_q  <= 1'b0;
        tx_loaded_q <= 1'b0;
        byte_full_q <= 1'b0;
        bitcnt_q    <= '0;
        is_addr_q   <= evt_i.start;
        state_q     <= evt_i.start ? ST_RX : ST_IDLE;
      end else begin
        unique case (state_q)
          ST_RX: begin
            if (evt_i.rise) begin
              shreg_q  <= {shreg_q[BYTE_W-2:0], evt_i.sda};
              bitcnt_q <= bitcnt_q + BCW'(1);
              if (bitcnt_q == LAST_BIT) begin
                byte_full_q <= 1'b1;
                if (!is_addr_q) begin
                  rx_valid_q <= 1'b1;
                  rx_taken_q <= 1'b0;
                  rx_data_q  <= {shreg_q[BYTE_W-2:0], evt_i.sda};
                end
              end
            end else if (evt_i.fall && byte_full_q) begin
              byte_full_q <= 1'b0;
              if (ack_ok) begin
                state_q     <= ST_RX_ACK;
                drive_low_q <= 1'b1;
                if (is_addr_q) begin
                  engaged_q <= 1'b1;
                  fstart_q  <= 1'b1;
                end
              end else begin
                state_q    <= ST_IGNORE;
                rx_valid_q <= 1'b0;
              end
            end
          end
          ST_RX_ACK: begin
            if (evt_i.fall) begin
              drive_low_q <= 1'b0;
              is_addr_q   <= 1'b0;
              bitcnt_q    <= '0;
              tx_loaded_q <= 1'b0;
              if (!is_addr_q && step_mode_i) begin
                state_q <= ST_STEP;
              end else if (!is_addr_q && tx_go) begin
                state_q     <= ST_TX;
                txsh_q      <= tx_next;
                drive_low_q <= ~tx_next[BYTE_W-1];
              end else begin
                state_q <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (evt_i.fall) begin
              if (bitcnt_q == LAST_BIT) begin
                state_q     <= ST_TX_ACK;
                drive_low_q <= 1'b0;
              end else begin
                txsh_q      <= {txsh_q[BYTE_W-2:0], 1'b0};
                drive_low_q <= ~txsh_q[BYTE_W-2];
                bitcnt_q    <= bitcnt_q + BCW'(1);
              end
            end
          end
          ST_TX_ACK: begin
            if (evt_i.fall) state_q <= ST_IGNORE;
          end
          ST_STEP: begin
            if (evt_i.rise) begin
              step_q    <= 1'b1;
              step_up_q <= evt_i.sda;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rx_data_o     = rx_data_q;
  assign rx_valid_o    = rx_valid_q;
  assign step_o        = step_q;
  assign step_up_o     = step_up_q;
  assign frame_start_o = fstart_q;
  assign frame_end_o   = fend_q;
  assign sda_low_o     = drive_low_q;
endmodule

// File: rtl/tws_slave_frontend.sv
module tws_slave_frontend
  import tws_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_drive_low_o,
  input  logic [3:0] strap_addr_i,
  input  logic       nv_busy_i,
  output logic [7:0] rx_data_o,
  output logic       rx_valid_o,
  input  logic       rx_ready_i,
  input  logic [7:0] tx_data_i,
  input  logic       tx_valid_i,
  output logic       tx_ready_o,
  input  logic       step_mode_i,
  output logic       step_o,
  output logic       step_up_o,
  output logic       frame_start_o,
  output logic       frame_end_o
);
  localparam int NUM_PINS = 2;
  localparam int SCL_IDX  = 1;
  localparam int SDA_IDX  = 0;

  logic [NUM_PINS-1:0] pin_raw, pin_flt;
  bus_evt_t            evt;

  assign pin_raw = {scl_i, sda_i};

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    tws_pin_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_flt (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_raw[g]),
      .level_o(pin_flt[g])
    );
  end

  tws_cond_detect u_cond (
    .clk  (clk),
    .rst_n(rst_n),
    .scl_f(pin_flt[SCL_IDX]),
    .sda_f(pin_flt[SDA_IDX]),
    .evt_o(evt)
  );

  tws_byte_engine u_eng (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_i        (evt),
    .strap_i      (strap_addr_i),
    .nv_busy_i    (nv_busy_i),
    .step_mode_i  (step_mode_i),
    .rx_data_o    (rx_data_o),
    .rx_valid_o   (rx_valid_o),
    .rx_ready_i   (rx_ready_i),
    .tx_data_i    (tx_data_i),
    .tx_valid_i   (tx_valid_i),
    .tx_ready_o   (tx_ready_o),
    .step_o       (step_o),
    .step_up_o    (step_up_o),
    .frame_start_o(frame_start_o),
    .frame_end_o  (frame_end_o),
    .sda_low_o    (sda_drive_low_o)
  );
endmodule

// File: rtl/tws_slave_frontend_chk.sv
module tws_slave_frontend_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       nv_busy_i,
  input logic [7:0] rx_data_o,
  input logic       rx_valid_o,
  input logic       rx_ready_i,
  input logic       tx_valid_i,
  input logic       tx_ready_o,
  input logic       step_o,
  input logic       frame_start_o,
  input logic       frame_end_o,
  input logic       sda_drive_low_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!sda_drive_low_o && !rx_valid_o && !step_o && !frame_start_o));

  // R2
  addr_ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> sda_drive_low_o);

  // R4
  busy_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> !$past(nv_busy_i));

  // R5
  rx_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i) |=> (!rx_valid_o || $stable(rx_data_o)));

  // R7
  tx_single_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

  // R8
  step_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> !step_o);

  // R9
  end_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_o |-> (!sda_drive_low_o && $onehot0({frame_start_o, frame_end_o})));
endmodule

bind tws_slave_frontend tws_slave_frontend_chk chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .nv_busy_i      (nv_busy_i),
  .rx_data_o      (rx_data_o),
  .rx_valid_o     (rx_valid_o),
  .rx_ready_i     (rx_ready_i),
  .tx_valid_i     (tx_valid_i),
  .tx_ready_o     (tx_ready_o),
  .step_o         (step_o),
  .frame_start_o  (frame_start_o),
  .frame_end_o    (frame_end_o),
  .sda_drive_low_o(sda_drive_low_o)
);

// File: tb/tws_slave_frontend_tb.sv
module tws_slave_frontend_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 5;
  localparam logic [3:0] STRAP = 4'b1011;
  localparam int NV = 7;
  // {address byte, data byte, busy, address acknowledged}
  localparam logic [17:0] VEC [NV] = '{
    {8'h5B, 8'hA5, 1'b0, 1'b1},
    {8'h5B, 8'h00, 1'b0, 1'b1},
    {8'h5B, 8'hFF, 1'b0, 1'b1},
    {8'h5A, 8'h3C, 1'b0, 1'b0},
    {8'hDB, 8'h3C, 1'b0, 1'b0},
    {8'h5B, 8'h81, 1'b1, 1'b0},
    {8'h4B, 8'h12, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_bus;
  logic sda_drive_low, rx_valid, tx_ready, step, step_up, fstart, fend;
  logic [7:0] rx_data;
  logic nv_busy = 1'b0, rx_ready = 1'b1, tx_valid = 1'b0, step_mode = 1'b0;
  logic [7:0] tx_data = 8'h00;

  int n_checks = 0, n_err = 0;
  int rx_cnt = 0, tx_cnt = 0, fs_cnt = 0, fe_cnt = 0, up_cnt = 0, dn_cnt = 0;
  logic [7:0] last_rx = 8'h00;

  assign sda_bus = sda_m & ~sda_drive_low;

  always #(CLK_PERIOD/2) clk = ~clk;

  tws_slave_frontend dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_drive_low_o(sda_drive_low), .strap_addr_i(STRAP), .nv_busy_i(nv_busy),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .step_mode_i(step_mode), .step_o(step), .step_up_o(step_up),
    .frame_start_o(fstart), .frame_end_o(fend)
  );

  always @(negedge clk) begin
    if (rx_valid && rx_ready) begin rx_cnt++; last_rx = rx_data; end
    if (tx_valid && tx_ready) tx_cnt++;
    if (fstart) fs_cnt++;
    if (fend) fe_cnt++;
    if (step && step_up) up_cnt++;
    if (step && !step_up) dn_cnt++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  // releases SDA for one clock and samples the bus in the middle of SCL high
  task automatic sample_bit(output logic b);
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sda_bus; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic a;
    logic [7:0] rd;
    int rx0, fs0, fe0;
    tick(5);
    // R1 reset state
    check("R1 drive", sda_drive_low, 0);
    check("R1 rx_valid", rx_valid, 0);
    check("R1 tx_ready", tx_ready, 0);
    check("R1 frame", {fstart, fend, step}, 0);
    rst_n = 1'b1;
    tick(4);

    // table walk: R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      rx0 = rx_cnt; fs0 = fs_cnt;
      nv_busy = VEC[v][1];
      bus_start();
      send_byte(VEC[v][17:10]);
      sample_bit(a);
      check(VEC[v][0] ? "R2 addr ack" : (VEC[v][1] ? "R4 busy nack" : "R3 mismatch nack"),
            a, !VEC[v][0]);
      send_byte(VEC[v][9:2]);
      sample_bit(a);
      check("R5 data ack", a, !VEC[v][0]);
      bus_stop();
      nv_busy = 1'b0;
      check("R5 rx count", rx_cnt - rx0, VEC[v][0] ? 1 : 0);
      if (VEC[v][0]) check("R5 rx data", last_rx, VEC[v][9:2]);
      check("R2 frame start", fs_cnt - fs0, VEC[v][0] ? 1 : 0);
    end

    // R7 read with R10 release in master ack slot
    tx_data = 8'hC6; tx_valid = 1'b1;
    bus_start(); send_byte(8'h5B); sample_bit(a);
    check("R7 addr ack", a, 0);
    check("R7 no take on addr", tx_cnt, 0);
    send_byte(8'h90); sample_bit(a);
    check("R7 instr ack", a, 0);
    tx_valid = 1'b0;
    check("R7 one take", tx_cnt, 1);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      sample_bit(b);
      rd[i] = b;
    end
    check("R7 read byte", rd, 8'hC6);
    sample_bit(a);
    check("R10 released in master ack", a, 1);
    bus_stop();

    // R8 stepping
    bus_start(); send_byte(8'h5B); sample_bit(a);
    send_byte(8'h20);
    step_mode = 1'b1;
    sample_bit(a);
    step_mode = 1'b0;
    check("R8 instr ack", a, 0);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    for (int i = 0; i < 2; i++) send_bit(1'b0);
    bus_stop();   // SCL rises once more with SDA low before the stop
    check("R8 up steps", up_cnt, 3);
    check("R8 down steps", dn_cnt, 3);

    // R6 byte not taken
    rx0 = rx_cnt;
    bus_start(); send_byte(8'h5B); sample_bit(a);
    rx_ready = 1'b0;
    send_byte(8'h33); sample_bit(a);
    check("R6 nack not taken", a, 1);
    rx_ready = 1'b1;
    send_byte(8'h44); sample_bit(a);
    check("R6 later byte ignored", a, 1);
    bus_stop();
    check("R6 rx count", rx_cnt - rx0, 0);

    // R9 repeated start mid byte
    rx0 = rx_cnt; fs0 = fs_cnt; fe0 = fe_cnt;
    bus_start(); send_byte(8'h5B); sample_bit(a);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_start(); send_byte(8'h5B); sample_bit(a);
    check("R9 re-address ack", a, 0);
    send_byte(8'h5A); sample_bit(a);
    bus_stop();
    check("R9 rx count", rx_cnt - rx0, 1);
    check("R9 rx data", last_rx, 8'h5A);
    check("R9 frame ends", fe_cnt - fe0, 2);
    check("R9 frame starts", fs_cnt - fs0, 2);
    check("R9 released", sda_drive_low, 0);

    // R11 short SCL glitch
    rx0 = rx_cnt;
    bus_start(); send_byte(8'h5B); sample_bit(a);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 8'h96 >> i;
      tick(2);
      scl = 1'b1; tick(1); scl = 1'b0;
      tick(Q - 3);
      scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
    end
    sample_bit(a);
    bus_stop();
    check("R11 ack", a, 0);
    check("R11 rx count", rx_cnt - rx0, 1);
    check("R11 rx data", last_rx, 8'h96);

    finish_run();
  end
endmodule